// File: doc/BRIEF.md
# MAC Device Control Register with Timed Soft Reset

This block holds the main device control word of a network MAC. A host reaches it through a simple register port: a write strobe, a byte address and 32 bits of write data, with read data produced combinationally from the address. The control word answers at its main offset and at one alias offset. A second register at its own offset holds the packet buffer allocation. It is the one register that keeps its contents across a soft reset.

A host write that sets the soft reset bit starts a timed sequence. The internal datapath reset output stays high for a parameter number of clock cycles. The mode fields return to their power-on values at once. When the count runs out, the reset bit clears by itself. The same write can also ask for a PHY reset. That request goes out as a single-cycle pulse, and only when a firmware gate input is high.

The duplex, speed and transmit flow-control fields track the auto-negotiation result while negotiation is enabled. Host writes reach them only when the link is forced. A non-volatile memory load port can preset the fields, but only when its 2-bit signature is valid.

Top module: `macctl_dev_ctrl`

## Requirements
- R1: After power-on reset, the control word reads 0x00000201: duplex bit 0 = 1, speed bits 9:8 = 10b, and every other bit 0. The allocation register reads 0 and the datapath reset output is low.
- R2: The control word is read and written at offset 0x000 and at the alias offset 0x004; both offsets reach the same storage. Unmapped addresses read 0.
- R3: A write to the control word with bit 26 = 1 while idle raises the datapath reset output from the next cycle for exactly RST_CYCLES cycles. Bit 26 reads 1 during that window and clears by itself afterwards.
- R4: The soft reset returns duplex, speed, VLAN and flow-control fields to their power-on values. The allocation register (offset ALLOC_OFS, low ALLOC_W bits) keeps its value and is cleared only by power-on reset.
- R5: While the soft reset is running, every register write and every memory load is ignored; reads still return current contents.
- R6: Bit 31 written together with bit 26 while the gate input is 1 gives a one-cycle pulse on the PHY reset output in the cycle after the write. Bit 31 reads as that pulse and is 0 at all other times.
- R7: Bit 31 written without bit 26, or with the gate input at 0, produces no PHY reset pulse.
- R8: Bit 30 holds VLAN enable and bit 28 holds transmit flow-control enable. Bit 29 always reads 0 whatever is written.
- R9: While auto-negotiation is enabled, duplex, speed and flow control take the negotiated inputs one cycle later, and host or memory writes to them are ignored. When negotiation is disabled, host writes set them.
- R10: A memory load with signature 01b copies bits 0, 9:8, 28 and 30 of the load word into the fields, with the link fields subject to R9. Any other signature leaves the fields unchanged, and a host write in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_wr | input | 1 | Register write strobe |
| req_addr | input | ADDR_W | Byte address for read and write |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for req_addr |
| fw_gate | input | 1 | Firmware gate enabling the PHY reset request |
| an_en | input | 1 | Auto-negotiation enabled |
| an_duplex | input | 1 | Negotiated duplex (1 = full) |
| an_speed | input | 2 | Negotiated speed code |
| an_txfc | input | 1 | Negotiated transmit flow control |
| nvm_load | input | 1 | Memory default load strobe |
| nvm_sig | input | 2 | Signature of the load word |
| nvm_word | input | 32 | Default control word |
| soft_rst_o | output | 1 | Internal datapath reset, high during the soft reset |
| phy_rst_req_o | output | 1 | One-cycle PHY reset request pulse |
| duplex_o | output | 1 | Active duplex mode |
| speed_o | output | 2 | Active speed code |
| vlan_en_o | output | 1 | VLAN mode enable |
| txfc_en_o | output | 1 | Transmit flow-control enable |

## Verification
Several properties are checked on every cycle:
- the soft reset window, once started, stays up until its counter empties;
- a PHY pulse lasts one cycle, always falls inside a soft reset and follows a high gate;
- the allocation register cannot change while the reset runs;
- the link fields follow the negotiated inputs whenever negotiation is on.

Only the bench scenarios can show the rest: the exact length of the reset window, the choice among host, memory and negotiation sources, the signature filter, and that the allocation value survives a soft reset but not a power-on reset.

// File: rtl/macctl_pkg.sv
package macctl_pkg;
   // Bit positions inside the control word
   localparam int CTL_DUPLEX = 0;
   localparam int CTL_SPD_LO = 8;
   localparam int CTL_SWRST  = 26;
   localparam int CTL_TXFC   = 28;
   localparam int CTL_RSVD   = 29;
   localparam int CTL_VLAN   = 30;
   localparam int CTL_PHYRST = 31;

   localparam logic [1:0] NVM_SIG_OK = 2'b01;

   typedef struct packed {
      logic       vlan;
      logic       txfc;
      logic [1:0] speed;
      logic       duplex;
   } mode_t;
endpackage

// File: rtl/macctl_rst_seq.sv
module macctl_rst_seq #(
   parameter int unsigned CYCLES = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         left_q <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         left_q <= LOAD;
      end else if (busy) begin
         if (left_q == '0) busy <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end

   // R3
   window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && left_q != '0) |=> busy);

   // R3
   window_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (left_q == LOAD));
endmodule

// File: rtl/macctl_mode_regs.sv
module macctl_mode_regs
   import macctl_pkg::*;
#(
   parameter bit         DEF_DUPLEX = 1'b1,
   parameter logic [1:0] DEF_SPEED  = 2'b10
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  host_we,
   input  mode_t host_val,
   input  logic  nvm_we,
   input  mode_t nvm_val,
   input  logic  an_en,
   input  logic  an_duplex,
   input  logic [1:0] an_speed,
   input  logic  an_txfc,
   output mode_t mode_q
);
   localparam mode_t DEFAULTS = '{vlan: 1'b0, txfc: 1'b0, speed: DEF_SPEED, duplex: DEF_DUPLEX};

   mode_t src, nxt;
   logic  src_we;

   always_comb begin
      src_we = host_we | nvm_we;
      src    = host_we ? host_val : nvm_val;
      nxt    = mode_q;
      if (src_we) begin
         nxt.vlan = src.vlan;
         if (!an_en) begin
            nxt.duplex = src.duplex;
            nxt.speed  = src.speed;
            nxt.txfc   = src.txfc;
         end
      end
      if (an_en) begin
         nxt.duplex = an_duplex;
         nxt.speed  = an_speed;
         nxt.txfc   = an_txfc;
      end
      if (clr) nxt = DEFAULTS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= DEFAULTS;
      else        mode_q <= nxt;
   end

   // R9
   an_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (an_en && !clr) |=> (mode_q.speed == $past(an_speed) && mode_q.duplex == $past(an_duplex)
                           && mode_q.txfc == $past(an_txfc)));

   // R4
   clr_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mode_q == DEFAULTS));
endmodule

// File: rtl/macctl_keep_reg.sv
module macctl_keep_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/macctl_dev_ctrl.sv
module macctl_dev_ctrl
   import macctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CTRL_OFS   = 'h0000,
   parameter bit          ALIAS_EN   = 1'b1,
   parameter int unsigned ALIAS_OFS  = 'h0004,
   parameter int unsigned ALLOC_OFS  = 'h1000,
   parameter int unsigned ALLOC_W    = 16,
   parameter int unsigned RST_CYCLES = 125000,
   parameter bit          DEF_DUPLEX = 1'b1,
   parameter logic [1:0]  DEF_SPEED  = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rd_data,
   input  logic              fw_gate,
   input  logic              an_en,
   input  logic              an_duplex,
   input  logic [1:0]        an_speed,
   input  logic              an_txfc,
   input  logic              nvm_load,
   input  logic [1:0]        nvm_sig,
   input  logic [31:0]       nvm_word,
   output logic              soft_rst_o,
   output logic              phy_rst_req_o,
   output logic              duplex_o,
   output logic [1:0]        speed_o,
   output logic              vlan_en_o,
   output logic              txfc_en_o
);
   // Elaboration-time parameter checks
   if (RST_CYCLES < 1) begin : g_bad_cycles
      $error("RST_CYCLES must be at least 1");
   end
   if (ALLOC_W < 1 || ALLOC_W > 32) begin : g_bad_alloc_w
      $error("ALLOC_W must be within 1..32");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("ADDR_W too small for the alias offset");
   end

   logic main_hit, alias_hit, ctrl_hit, alloc_hit;
   logic busy, sr_start, host_we, nvm_we, alloc_we, phy_q;
   mode_t host_val, nvm_val, mode_q;
   logic [ALLOC_W-1:0] alloc_q;

   assign main_hit  = (req_addr == ADDR_W'(CTRL_OFS));
   assign alloc_hit = (req_addr == ADDR_W'(ALLOC_OFS));

   if (ALIAS_EN) begin : g_alias
      assign alias_hit = (req_addr == ADDR_W'(ALIAS_OFS));
   end else begin : g_no_alias
      assign alias_hit = 1'b0;
   end

   assign ctrl_hit = main_hit | alias_hit;
   assign sr_start = req_wr && ctrl_hit && req_wdata[CTL_SWRST] && !busy;
   assign host_we  = req_wr && ctrl_hit && !busy;
   assign nvm_we   = nvm_load && (nvm_sig == NVM_SIG_OK) && !busy;
   assign alloc_we = req_wr && alloc_hit && !busy;

   function automatic mode_t word2mode(input logic [31:0] w);
      mode_t m;
      m.vlan   = w[CTL_VLAN];
      m.txfc   = w[CTL_TXFC];
      m.speed  = w[CTL_SPD_LO +: 2];
      m.duplex = w[CTL_DUPLEX];
      return m;
   endfunction

   assign host_val = word2mode(req_wdata);
   assign nvm_val  = word2mode(nvm_word);

   macctl_rst_seq #(.CYCLES(RST_CYCLES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sr_start),
      .busy  (busy)
   );

   macctl_mode_regs #(.DEF_DUPLEX(DEF_DUPLEX), .DEF_SPEED(DEF_SPEED)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (sr_start),
      .host_we   (host_we),
      .host_val  (host_val),
      .nvm_we    (nvm_we),
      .nvm_val   (nvm_val),
      .an_en     (an_en),
      .an_duplex (an_duplex),
      .an_speed  (an_speed),
      .an_txfc   (an_txfc),
      .mode_q    (mode_q)
   );

   macctl_keep_reg #(.W(ALLOC_W)) u_alloc (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (alloc_we),
      .d     (req_wdata[ALLOC_W-1:0]),
      .q     (alloc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phy_q <= 1'b0;
      else        phy_q <= sr_start && req_wdata[CTL_PHYRST] && fw_gate;
   end

   always_comb begin
      rd_data = '0;
      if (ctrl_hit) begin
         rd_data[CTL_DUPLEX]        = mode_q.duplex;
         rd_data[CTL_SPD_LO +: 2]   = mode_q.speed;
         rd_data[CTL_SWRST]         = busy;
         rd_data[CTL_TXFC]          = mode_q.txfc;
         rd_data[CTL_RSVD]          = 1'b0;
         rd_data[CTL_VLAN]          = mode_q.vlan;
         rd_data[CTL_PHYRST]        = phy_q;
      end else if (alloc_hit) begin
         rd_data[ALLOC_W-1:0] = alloc_q;
      end
   end

   assign soft_rst_o    = busy;
   assign phy_rst_req_o = phy_q;
   assign duplex_o      = mode_q.duplex;
   assign speed_o       = mode_q.speed;
   assign vlan_en_o     = mode_q.vlan;
   assign txfc_en_o     = mode_q.txfc;

   logic unused_bits;
   assign unused_bits = ^{req_wdata, nvm_word};

   // R6
   phy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_q |=> !phy_q);

   // R6
   phy_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_q |-> busy);

   // R7
   phy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_q |-> $past(fw_gate));

   // R4
   alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(alloc_q));

   // R8
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |-> (rd_data[CTL_RSVD] == 1'b0));
endmodule

// File: tb/macctl_dev_ctrl_test.sv
module macctl_dev_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int RST_CYC    = 12;
   localparam int ALLOC_W    = 20;
   localparam logic [15:0] ALLOC_A = 16'h1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_wr = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic fw_gate = 1'b0, an_en = 1'b0, an_duplex = 1'b0, an_txfc = 1'b0;
   logic [1:0] an_speed = 2'b00;
   logic nvm_load = 1'b0;
   logic [1:0] nvm_sig = 2'b00;
   logic [31:0] nvm_word = '0;
   logic soft_rst_o, phy_rst_req_o, duplex_o, vlan_en_o, txfc_en_o;
   logic [1:0] speed_o;

   int vectors = 0;
   int errors  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   macctl_dev_ctrl #(.ALLOC_W(ALLOC_W), .ALLOC_OFS(32'h1000), .RST_CYCLES(RST_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rd_data), .fw_gate(fw_gate), .an_en(an_en), .an_duplex(an_duplex),
      .an_speed(an_speed), .an_txfc(an_txfc), .nvm_load(nvm_load), .nvm_sig(nvm_sig),
      .nvm_word(nvm_word), .soft_rst_o(soft_rst_o), .phy_rst_req_o(phy_rst_req_o),
      .duplex_o(duplex_o), .speed_o(speed_o), .vlan_en_o(vlan_en_o), .txfc_en_o(txfc_en_o));

   // Behavioural reference model
   bit m_busy, m_phy, m_dup, m_vlan, m_txfc;
   bit [1:0] m_spd;
   int m_left;
   bit [31:0] m_alloc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_phy = 0; m_dup = 1; m_spd = 2'b10; m_vlan = 0; m_txfc = 0;
         m_left = 0; m_alloc = 0;
      end else begin
         bit ctrl_w, start, wbusy;
         ctrl_w = req_wr && (req_addr == 16'h0000 || req_addr == 16'h0004);
         wbusy  = m_busy;
         start  = ctrl_w && req_wdata[26] && !wbusy;
         m_phy  = start && req_wdata[31] && fw_gate;
         if (start) begin
            m_dup = 1; m_spd = 2'b10; m_vlan = 0; m_txfc = 0;
         end else begin
            if (!wbusy && ctrl_w) begin
               m_vlan = req_wdata[30];
               if (!an_en) begin m_dup = req_wdata[0]; m_spd = req_wdata[9:8]; m_txfc = req_wdata[28]; end
            end else if (!wbusy && nvm_load && nvm_sig == 2'b01) begin
               m_vlan = nvm_word[30];
               if (!an_en) begin m_dup = nvm_word[0]; m_spd = nvm_word[9:8]; m_txfc = nvm_word[28]; end
            end
            if (an_en) begin m_dup = an_duplex; m_spd = an_speed; m_txfc = an_txfc; end
         end
         if (!wbusy && req_wr && req_addr == ALLOC_A) m_alloc = {12'd0, req_wdata[ALLOC_W-1:0]};
         if (start) begin m_busy = 1; m_left = RST_CYC - 1; end
         else if (m_busy) begin
            if (m_left == 0) m_busy = 0; else m_left = m_left - 1;
         end
      end
   end

   function automatic bit [31:0] model_read(input logic [15:0] a);
      bit [31:0] w = 0;
      if (a == 16'h0000 || a == 16'h0004) begin
         w[0] = m_dup; w[9:8] = m_spd; w[26] = m_busy; w[28] = m_txfc; w[30] = m_vlan; w[31] = m_phy;
      end else if (a == ALLOC_A) w = m_alloc;
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R3 soft_rst_o", 32'(soft_rst_o), 32'(m_busy));
         chk("R6 phy_rst_req_o", 32'(phy_rst_req_o), 32'(m_phy));
         chk("R9 duplex_o", 32'(duplex_o), 32'(m_dup));
         chk("R9 speed_o", 32'(speed_o), 32'(m_spd));
         chk("R9 txfc_en_o", 32'(txfc_en_o), 32'(m_txfc));
         chk("R8 vlan_en_o", 32'(vlan_en_o), 32'(m_vlan));
         chk("R2 rd_data", rd_data, model_read(req_addr));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      req_wr = 1; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      req_wr = 0;
   endtask

   task automatic nvm(input logic [1:0] s, input logic [31:0] d);
      @(posedge clk); #1;
      nvm_load = 1; nvm_sig = s; nvm_word = d;
      @(posedge clk); #1;
      nvm_load = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
      req_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      int cnt;
      idle(3);
      rst_n = 1;
      idle(1);
      // R1 power-on state
      rd_chk("R1 ctrl reset", 16'h0000, 32'h0000_0201);
      rd_chk("R1 alloc reset", ALLOC_A, 32'h0);
      chk("R1 soft_rst low", 32'(soft_rst_o), 32'h0);

      // R2 unmapped, allocation write
      wr(ALLOC_A, 32'hFFFA_BCDE);
      rd_chk("R4 alloc written", ALLOC_A, 32'h000A_BCDE);
      rd_chk("R2 unmapped", 16'h2000, 32'h0);

      // R8 field writes, reserved bit
      wr(16'h0000, 32'h7000_0100);
      rd_chk("R8 ctrl fields", 16'h0000, 32'h5000_0100);
      chk("R8 vlan", 32'(vlan_en_o), 32'h1);
      rd_chk("R2 alias read", 16'h0004, 32'h5000_0100);
      wr(16'h0004, 32'h0000_0201);
      rd_chk("R2 alias write", 16'h0000, 32'h0000_0201);

      // R9 auto-negotiation overrides host
      an_en = 1; an_duplex = 1; an_speed = 2'b01; an_txfc = 1;
      idle(1);
      wr(16'h0000, 32'h4000_0200);
      rd_chk("R9 an override", 16'h0000, 32'h5000_0101);
      an_speed = 2'b00; an_duplex = 0;
      idle(1);
      chk("R9 an follow speed", 32'(speed_o), 32'h0);
      an_en = 0;
      idle(1);

      // R10 memory load signature filter
      nvm(2'b10, 32'h0000_0300);
      rd_chk("R10 bad signature", 16'h0000, 32'h5000_0000);
      nvm(2'b01, 32'h0000_0300);
      rd_chk("R10 good signature", 16'h0000, 32'h0000_0300);

      // R7 PHY request without soft reset
      fw_gate = 1;
      wr(16'h0000, 32'h8000_0300);
      chk("R7 no pulse without reset", 32'(phy_rst_req_o), 32'h0);
      chk("R7 no reset started", 32'(soft_rst_o), 32'h0);

      // R6 soft reset with PHY request
      wr(16'h0000, 32'h8400_0000);
      chk("R6 pulse", 32'(phy_rst_req_o), 32'h1);
      rd_chk("R6 readback", 16'h0000, 32'h8400_0201);
      idle(1);
      chk("R6 pulse one cycle", 32'(phy_rst_req_o), 32'h0);
      // R5 writes ignored while busy
      wr(ALLOC_A, 32'h0001_2345);
      wr(16'h0000, 32'h4000_0000);
      nvm(2'b01, 32'h4000_0000);
      rd_chk("R5 ctrl unchanged", 16'h0000, 32'h0400_0201);
      rd_chk("R5 alloc unchanged", ALLOC_A, 32'h000A_BCDE);
      cnt = 0;
      while (soft_rst_o && cnt < 100) begin cnt++; idle(1); end
      rd_chk("R4 alloc survives", ALLOC_A, 32'h000A_BCDE);
      rd_chk("R4 fields default", 16'h0000, 32'h0000_0201);

      // R3 window length, gate low
      fw_gate = 0;
      wr(16'h0004, 32'h8400_0000);
      chk("R7 gate low no pulse", 32'(phy_rst_req_o), 32'h0);
      rd_chk("R3 bit26 set", 16'h0000, 32'h0400_0201);
      cnt = 0;
      while (soft_rst_o && cnt < 100) begin cnt++; idle(1); end
      chk("R3 window length", 32'(cnt), 32'(RST_CYC));
      rd_chk("R3 bit26 cleared", 16'h0000, 32'h0000_0201);

      // R4 power-on clears allocation
      rst_n = 0;
      idle(2);
      rst_n = 1;
      idle(1);
      rd_chk("R4 alloc power-on clear", ALLOC_A, 32'h0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule